// File: doc/BRIEF.md
# Cubic-Convergence Reciprocal Refinement Unit

This block computes the reciprocal of an unsigned fixed-point operand `a` in [1, 2). It delivers the result to full output precision from a coarse starting estimate. A small lookup table, addressed by the leading fraction bits of `a`, supplies an estimate `x` that is good to about `M` bits. One third-order correction step then finishes the result. The step forms the residual `h = 1 - a*x`, squares it, and applies `x + x*(h + h*h)`. This roughly triples the number of correct bits, so an 11-bit estimate is enough for a 32-bit result.

The datapath is a fixed-latency pipeline with one register stage per multiply. It accepts a new operand on every cycle that `in_valid` is high, and the result appears `LATENCY` cycles later with `out_valid`. The residual is carried as a signed quantity, because the estimate may lie above the true reciprocal. Since the residual is tiny, the squarer works on a truncated copy of it and keeps only the product bits that can still affect the result. The correction multiplier also uses only the narrow estimate.

Top module: `recip_cubic_refine`

## Requirements
- R1: With `in_a = A` (W bits, MSB set, value `A/2^(W-1)`) and the result `Q` on `out_recip` (W+1 bits, value `Q/2^W`), `Q` equals `floor(2^(2W-1)/A)`, or that value plus one when the division is inexact. This holds for arbitrary operands.
- R2: Every cycle with `in_valid` high yields exactly one result, with `out_valid` high exactly 5 cycles later (`LATENCY`). Back-to-back operands give back-to-back results in the same order.
- R3: The operand 1.0 (`A = 2^(W-1)`) returns exactly `Q = 2^W`.
- R4: Every result lies in [2^(W-1), 2^W]. When bit W of `out_recip` is set, all lower bits are zero. This holds up to and including the largest operand `2^W - 1`.
- R5: The estimate table is indexed by the `M` bits of `in_a` just below its MSB. Operands on both sides of an interval boundary (the last code of interval k-1 and the first code of interval k) both meet R1. Each estimate lies in [0.5, 1), and the residual magnitude stays below `2^-(M-1)`.
- R6: While `rst` is high and on the first cycle after it, `out_valid` is low.
- R7: Cycles with `in_valid` low produce no result: `out_valid` is low 5 cycles after such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand on `in_a` is accepted this cycle |
| in_a | input | W | Operand, 1 integer bit and W-1 fraction bits, MSB must be 1 |
| out_valid | output | 1 | `out_recip` holds a result this cycle |
| out_recip | output | W+1 | Reciprocal, 1 integer bit and W fraction bits |

## Verification
The two functions that fall in the same cycle are the acceptance of a new operand and the emission of an earlier result. The estimate read and correction of one operand also overlap the residual multiply of the next operand. Both situations are provoked by streaming operands on consecutive cycles and by an irregular pattern of idle cycles inside a stream. Each cycle is judged against a history of driven operands delayed by the pipeline latency. A set valid must carry the reciprocal of exactly the operand driven five cycles earlier. A clear valid must match an idle slot, so any slip, duplication or loss of a result shows up as a miscompare.

// File: rtl/recip_pkg.sv
package recip_pkg;
  // Rounded reciprocal of the midpoint of estimate interval idx, scaled by 2^sf.
  function automatic logic [63:0] seed_entry(input int idx, input int m, input int sf);
    logic [63:0] num;
    logic [63:0] den;
    num = 64'd1 << (sf + m + 2);
    den = (64'd1 << (m + 1)) + 64'(2 * idx + 1);
    return ((num / den) + 64'd1) >> 1;
  endfunction
endpackage

// File: rtl/recip_seed_rom.sv
module recip_seed_rom #(
  parameter int W  = 32,
  parameter int M  = 11,
  parameter int SF = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_a,
  output logic          out_valid,
  output logic [W-1:0]  out_a,
  output logic [SF-1:0] out_seed
);
  localparam int DEPTH = 1 << M;

  logic [SF-1:0] rom [DEPTH];
  logic [M-1:0]  idx;

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = SF'(recip_pkg::seed_entry(i, M, SF));
  end

  assign idx = in_a[W-2 -: M];

  // Synchronous read, no reset on the data path so block RAM can be used.
  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_seed <= rom[idx];
      out_a    <= in_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // R5
  seed_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_seed[SF-1]);
endmodule

// File: rtl/recip_residual.sv
module recip_residual #(
  parameter int W  = 32,
  parameter int M  = 11,
  parameter int SF = 13,
  parameter int F  = 38,
  parameter int HW = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_a,
  input  logic [SF-1:0] in_x,
  output logic          out_valid,
  output logic [HW-1:0] out_h,
  output logic [SF-1:0] out_x
);
  localparam int PF  = W - 1 + SF;   // fraction bits of a*x
  localparam int HSH = PF - F;       // bits dropped to reach weight 2^-F
  localparam int HP  = HSH + HW;     // product width kept (higher bits cancel)
  localparam logic [HP-1:0] ONE_P = (PF < HP) ? (HP'(1) << PF) : '0;
  localparam logic [HW-1:0] HLIM  = HW'(1) << (F - M + 1);

  logic [HP-1:0] prod;
  logic [HP-1:0] h_full;
  logic [HW-1:0] h_next;

  always_comb begin
    prod   = HP'(in_a) * HP'(in_x);
    h_full = ONE_P - prod;
    h_next = h_full[HP-1:HSH] + HW'(h_full[HSH-1]);
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_h <= h_next;
      out_x <= in_x;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // R5
  residual_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (($signed(out_h) < $signed(HLIM)) && ($signed(out_h) > -$signed(HLIM))));
endmodule

// File: rtl/recip_correct.sv
module recip_correct #(
  parameter int M  = 11,
  parameter int SF = 13,
  parameter int F  = 38,
  parameter int HW = 30
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [HW-1:0]  in_h,
  input  logic [SF-1:0]  in_x,
  output logic           out_valid,
  output logic [HW:0]    out_t,
  output logic [SF-1:0]  out_x
);
  localparam int D    = M - 3;            // low residual bits dropped before squaring
  localparam int HSW  = HW - D;
  localparam int SQSH = F - 2 * D;        // square bits below weight 2^-F
  localparam int SQW  = F - 2 * M + 3;    // square kept at weights 2^-F and up
  localparam int PW   = SQSH + SQW;
  localparam int SW2  = HW + 1;
  localparam int TW   = SF + SW2;

  // stage A: narrowed square of the residual
  logic [HSW-1:0] hs;
  logic [PW-1:0]  hs_ext;
  logic [PW-1:0]  sq_prod;
  logic [SQW-1:0] sq_next;
  logic [SQW-1:0] sq_r;
  logic [HW-1:0]  h_q;
  logic [SF-1:0]  x_q;
  logic           v_q;

  always_comb begin
    hs      = in_h[HW-1:D];
    hs_ext  = {{(PW-HSW){hs[HSW-1]}}, hs};
    sq_prod = hs_ext * hs_ext;
    sq_next = sq_prod[PW-1:SQSH] + SQW'(sq_prod[SQSH-1]);
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      sq_r <= sq_next;
      h_q  <= in_h;
      x_q  <= in_x;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= in_valid;
  end

  // R1
  square_bound_chk: assert property (@(posedge clk) disable iff (rst)
    v_q |-> !sq_r[SQW-1]);

  // stage B: x * (h + h^2) with the narrow estimate as multiplier
  logic [SW2-1:0] s;
  logic [TW-1:0]  x_ext;
  logic [TW-1:0]  s_ext;
  logic [TW-1:0]  tprod;
  logic [SW2-1:0] t_next;

  always_comb begin
    s      = {h_q[HW-1], h_q} + {{(SW2-SQW){1'b0}}, sq_r};
    x_ext  = {{(TW-SF){1'b0}}, x_q};
    s_ext  = {{(TW-SW2){s[SW2-1]}}, s};
    tprod  = x_ext * s_ext;
    t_next = tprod[TW-1:SF] + SW2'(tprod[SF-1]);
  end

  always_ff @(posedge clk) begin
    if (v_q) begin
      out_t <= t_next;
      out_x <= x_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v_q;
  end
endmodule

// File: rtl/recip_cubic_refine.sv
module recip_cubic_refine #(
  parameter int W = 32,
  parameter int M = 11,
  parameter int G = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  output logic         out_valid,
  output logic [W:0]   out_recip
);
  localparam int SF      = M + 2;       // estimate fraction bits
  localparam int F       = W + G;       // internal fraction bits
  localparam int HW      = F - M + 3;   // signed residual width
  localparam int SW2     = HW + 1;
  localparam int LATENCY = 5;

  logic          v1, v2, v4;
  logic [W-1:0]  a1;
  logic [SF-1:0] x1, x2, x4;
  logic [HW-1:0] h2;
  logic [SW2-1:0] t4;

  recip_seed_rom #(.W(W), .M(M), .SF(SF)) u_seed (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a),
    .out_valid(v1), .out_a(a1), .out_seed(x1));

  recip_residual #(.W(W), .M(M), .SF(SF), .F(F), .HW(HW)) u_resid (
    .clk(clk), .rst(rst), .in_valid(v1), .in_a(a1), .in_x(x1),
    .out_valid(v2), .out_h(h2), .out_x(x2));

  recip_correct #(.M(M), .SF(SF), .F(F), .HW(HW)) u_corr (
    .clk(clk), .rst(rst), .in_valid(v2), .in_h(h2), .in_x(x2),
    .out_valid(v4), .out_t(t4), .out_x(x4));

  // final stage: x + correction, round to nearest at weight 2^-W
  logic [F:0] y;
  logic [W:0] q_next;

  always_comb begin
    y      = {1'b0, x4, {(F-SF){1'b0}}} + {{(F+1-SW2){t4[SW2-1]}}, t4};
    q_next = y[F:G] + (W+1)'(y[G-1]);
  end

  always_ff @(posedge clk) begin
    if (v4) out_recip <= q_next;
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v4;
  end

  // R4
  upper_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_recip[W]) |-> (out_recip[W-1:0] == '0));
  // R4
  lower_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_recip[W] || out_recip[W-1]));
endmodule

// File: tb/test_recip_cubic_refine.sv
module test_recip_cubic_refine;
  localparam int W   = 32;
  localparam int M   = 11;
  localparam int LAT = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0;
  logic         out_valid;
  logic [W:0]   out_recip;

  int    n_checks = 0;
  int    n_fails  = 0;
  string tag      = "R6";
  logic         hv [0:LAT];
  logic [W-1:0] ha [0:LAT];

  always #5 clk = ~clk;

  recip_cubic_refine #(.W(W), .M(M)) i_recip_cubic_refine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a),
    .out_valid(out_valid), .out_recip(out_recip));

  function automatic logic [2*W:0] quot(input logic [W-1:0] a);
    logic [2*W:0] num;
    num = (2*W+1)'(1) << (2*W-1);
    return num / (2*W+1)'(a);
  endfunction

  function automatic bit inexact(input logic [W-1:0] a);
    logic [2*W:0] num;
    num = (2*W+1)'(1) << (2*W-1);
    return (num % (2*W+1)'(a)) != 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Result monitor: compares each cycle with the operand driven LAT cycles before.
  always @(negedge clk) begin
    #1;
    if (rst) begin
      for (int i = 0; i <= LAT; i++) begin hv[i] = 1'b0; ha[i] = '0; end
    end else begin
      for (int i = LAT; i > 0; i--) begin hv[i] = hv[i-1]; ha[i] = ha[i-1]; end
      hv[0] = in_valid;
      ha[0] = in_a;
      if (hv[LAT]) begin
        logic [W:0] f;
        bit ok;
        f  = (W+1)'(quot(ha[LAT]));
        ok = (out_recip == f) || (inexact(ha[LAT]) && out_recip == f + 1'b1);
        check(out_valid == 1'b1, "R2", "valid after latency", {{W{1'b0}}, out_valid}, 1);
        check(ok, tag, "faithful reciprocal", out_recip, f);
        check(out_recip >= ((W+1)'(1) << (W-1)) && out_recip <= ((W+1)'(1) << W),
              "R4", "result range", out_recip, (W+1)'(1) << W);
        if (ha[LAT] == (W'(1) << (W-1)))
          check(out_recip == ((W+1)'(1) << W), "R3", "exact unity", out_recip, (W+1)'(1) << W);
      end else begin
        check(out_valid == 1'b0, "R7", "no result for idle slot", {{W{1'b0}}, out_valid}, 0);
      end
    end
  end

  task automatic drive(input logic [W-1:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_a     = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a     = '0;
    end
  endtask

  task automatic t_reset();
    tag = "R6";
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R6", "valid low in reset", {{W{1'b0}}, out_valid}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R6", "valid low after reset", {{W{1'b0}}, out_valid}, 0);
    idle(LAT + 1);
  endtask

  task automatic t_unity();
    tag = "R3";
    drive(W'(1) << (W-1));
    drive((W'(1) << (W-1)) + 1'b1);
    drive(W'(1) << (W-1));
    idle(LAT + 1);
  endtask

  task automatic t_top_edge();
    tag = "R4";
    drive('1);
    drive({W{1'b1}} - 1'b1);
    drive({2'b11, {(W-2){1'b0}}});
    drive({1'b1, {(W-2){1'b0}}, 1'b1});
    idle(LAT + 1);
  endtask

  task automatic t_boundaries();
    int ks [8] = '{1, 2, 3, 512, 1023, 1024, 1536, 2047};
    tag = "R5";
    foreach (ks[j]) begin
      logic [W-1:0] first;
      first = (W'(1) << (W-1)) | (W'(ks[j]) << (W-1-M));
      drive(first - 1'b1);
      drive(first);
      drive(first + 1'b1);
    end
    idle(LAT + 1);
  endtask

  task automatic t_random_stream();
    tag = "R1";
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] r;
      r = $urandom();
      drive({1'b1, r[W-2:0]});
    end
    idle(LAT + 1);
  endtask

  task automatic t_bubbles();
    tag = "R2";
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom();
      if ((i % 3 == 0) || (i % 7 == 5)) idle(1);
      else drive({1'b1, r[W-2:0]});
    end
    idle(LAT + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    t_reset();
    t_unity();
    t_top_edge();
    t_boundaries();
    t_random_stream();
    t_bubbles();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule